// File: doc/BRIEF.md
# PWM Time-Base Counter with Double-Buffered Period

This block produces the time base for a pulse-width modulator. A counter steps once per prescaled tick and runs against a programmable period in one of three counting shapes: a rising sawtooth, a falling sawtooth, or a triangle. Comparators outside the block use the counter value, the direction flag and two event pulses. One pulse marks the counter at zero. The other marks the counter at the active period.

Software reaches the period through one read/write port. A load-mode input selects which copy that port addresses. In buffered mode the port addresses a shadow copy, and the block moves the shadow into the active period whenever the counter stands at zero on an advancing tick. In immediate mode the port addresses the active period, and the new value applies from the next cycle. A shared start-enable input gates all counting, so several instances fed the same tick begin on the same edge.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset the counter is 0, the direction flag is 0 (up), both event pulses are low, and both period copies are 0.
- R2: With mode code 00 (up) the counter rises by one per advancing tick from 0 to the active period and then returns to 0. The cycle is period+1 ticks long and the direction flag is 0.
- R3: With mode code 01 (down) the counter falls by one per advancing tick. On the tick that finds it at 0 it reloads the active period, and the direction flag is 1.
- R4: With mode code 10 (up-down) the counter rises from 0 to the period and falls back to 0, for a cycle of 2×period ticks. The direction flag becomes 1 on the tick that leaves the peak and becomes 0 on the tick that leaves zero.
- R5: With the load-mode input at 0, a period write and the read data both use the shadow copy. The active period takes the shadow value on each advancing tick that finds the counter at 0. A write in that same cycle stays in the shadow and first takes effect at the following zero.
- R6: With the load-mode input at 1, a period write and the read data both use the active copy, and the written value applies from the next cycle.
- R7: The counter and the direction flag change only on cycles where both the tick enable and the start enable are 1. On any other cycle both hold and neither event pulse is raised.
- R8: The zero pulse is high for one cycle on an advancing tick when the counter is 0. The period pulse is high for one cycle on an advancing tick when the counter equals a nonzero active period and the mode is not stop. In up-down mode the period pulse therefore fires once per peak.
- R9: With mode code 11 (stop), or with an active period of 0, each advancing tick drives the counter to 0 and clears the direction flag. The zero pulse fires on every such tick while the counter is 0, and the period pulse stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled time-base tick enable |
| sync_start | input | 1 | Shared start enable; counting runs only while high |
| cnt_mode | input | 2 | 00 up, 01 down, 10 up-down, 11 stop |
| imm_load | input | 1 | 0: port uses the shadow period, 1: port uses the active period |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | CNT_W | Period write data |
| prd_rdata | output | CNT_W | Period read data from the copy selected by imm_load |
| tb_cnt | output | CNT_W | Counter value |
| cnt_down | output | 1 | Direction flag, 1 while counting down |
| zero_hit | output | 1 | Zero-match pulse |
| prd_hit | output | 1 | Period-match pulse |

## Verification
Two functions can fall in one cycle: the zero-tick copy from shadow to active, and a software write to the shadow. The bench forces them together by writing a new period in the same cycle that the zero pulse is high. It then judges the outcome by reading the shadow back and by checking where the next peak lands: the peak must stay at the old period for one more cycle, and the new value must appear only after the following zero.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_STOP = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic zero;
        logic peak;
    } tb_evt_t;

    function automatic cnt_mode_e to_mode(input logic [1:0] code);
        return cnt_mode_e'(code);
    endfunction

endpackage

// File: rtl/ptb_period_reg.sv
module ptb_period_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             imm_load,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             xfer,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_en && !imm_load) shadow <= wr_data;
            if (wr_en && imm_load)
                active <= wr_data;
            else if (xfer && !imm_load)
                active <= shadow;
        end
    end

    assign rd_data = imm_load ? active : shadow;

    // R5: in buffered mode the active copy moves only on a zero transfer
    a_r5_active_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(imm_load) && !$past(xfer)) |-> $stable(active));

    // R5: a zero transfer takes the shadow as it stood before the edge
    a_r5_xfer_old_shadow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(imm_load) && $past(xfer)) |-> active == $past(shadow));

    // R6: an immediate write is visible on the next cycle
    a_r6_imm_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(imm_load) && $past(wr_en)) |-> active == $past(wr_data));

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output tb_evt_t          evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_n;
    logic             dir_n;
    logic             idle;

    assign idle = (mode == CM_STOP) || (period == '0);

    always_comb begin
        cnt_n = cnt;
        dir_n = dir_down;
        if (adv) begin
            if (idle) begin
                cnt_n = '0;
                dir_n = 1'b0;
            end else begin
                case (mode)
                    CM_UP: begin
                        dir_n = 1'b0;
                        cnt_n = (cnt >= period) ? '0 : cnt + ONE;
                    end
                    CM_DOWN: begin
                        dir_n = 1'b1;
                        cnt_n = (cnt == '0 || cnt > period) ? period : cnt - ONE;
                    end
                    default: begin
                        if (!dir_down) begin
                            if (cnt >= period) begin
                                cnt_n = cnt - ONE;
                                dir_n = 1'b1;
                            end else begin
                                cnt_n = cnt + ONE;
                            end
                        end else if (cnt == '0) begin
                            cnt_n = ONE;
                            dir_n = 1'b0;
                        end else begin
                            cnt_n = cnt - ONE;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else begin
            cnt      <= cnt_n;
            dir_down <= dir_n;
        end
    end

    assign evt.zero = adv && (cnt == '0);
    assign evt.peak = adv && !idle && (cnt == period);

    // R7: no advancing tick, no movement
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(adv)) |-> ($stable(cnt) && $stable(dir_down)));

    // R2: up mode wraps from the period to zero
    a_r2_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(mode) == CM_UP && $past(period) != '0
         && $past(cnt) == $past(period)) |-> cnt == '0);

    // R3: down mode reloads the period from zero
    a_r3_down_reload: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(mode) == CM_DOWN && $past(period) != '0
         && $past(cnt) == '0) |-> (cnt == $past(period) && dir_down));

    // R4: up-down mode turns around at the peak
    a_r4_peak_turn: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(mode) == CM_UPDN && $past(period) != '0
         && !$past(dir_down) && $past(cnt) == $past(period))
        |-> (dir_down && cnt == $past(period) - ONE));

    // R9: stop mode parks the counter at zero
    a_r9_stop_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(mode) == CM_STOP) |-> (cnt == '0 && !dir_down));

    // R8: the two events never fire together on a live period
    a_r8_evt_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.zero, evt.peak}));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             sync_start,
    input  logic [1:0]       cnt_mode,
    input  logic             imm_load,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] prd_rdata,
    output logic [CNT_W-1:0] tb_cnt,
    output logic             cnt_down,
    output logic             zero_hit,
    output logic             prd_hit
);
    logic             adv;
    logic [CNT_W-1:0] prd_active;
    tb_evt_t          evt;

    assign adv = tick_en && sync_start;

    ptb_period_reg #(.CNT_W(CNT_W)) u_prd (
        .clk     (clk),
        .rst     (rst),
        .imm_load(imm_load),
        .wr_en   (prd_wr),
        .wr_data (prd_wdata),
        .xfer    (evt.zero),
        .rd_data (prd_rdata),
        .active  (prd_active)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .mode    (to_mode(cnt_mode)),
        .period  (prd_active),
        .cnt     (tb_cnt),
        .dir_down(cnt_down),
        .evt     (evt)
    );

    assign zero_hit = evt.zero;
    assign prd_hit  = evt.peak;

    // R7: events need an advancing tick
    a_r7_no_evt_idle: assert property (@(posedge clk) disable iff (rst)
        !adv |-> (!zero_hit && !prd_hit));

endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

    typedef struct {
        logic [15:0] cnt;
        logic        dir;
        logic        z;
        logic        p;
        logic        rd_chk;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        sync_start = 1'b0;
    logic [1:0]  cnt_mode = 2'b00;
    logic        imm_load = 1'b0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] prd_rdata;
    logic [15:0] tb_cnt;
    logic        cnt_down;
    logic        zero_hit;
    logic        prd_hit;

    logic [1:0]  m_mode = 2'b00;
    logic        m_imm = 1'b0;
    logic        m_sync = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    pwm_timebase #(.CNT_W(16)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .sync_start(sync_start),
        .cnt_mode(cnt_mode), .imm_load(imm_load), .prd_wr(prd_wr),
        .prd_wdata(prd_wdata), .prd_rdata(prd_rdata), .tb_cnt(tb_cnt),
        .cnt_down(cnt_down), .zero_hit(zero_hit), .prd_hit(prd_hit)
    );

    task automatic step(input string tag, input logic t, input logic w,
                        input logic [15:0] d, input logic [15:0] ec, input logic ed,
                        input logic ez, input logic ep, input logic rc,
                        input logic [15:0] er);
        exp_t e;
        @(negedge clk);
        tick_en    = t;
        prd_wr     = w;
        prd_wdata  = d;
        cnt_mode   = m_mode;
        imm_load   = m_imm;
        sync_start = m_sync;
        e.cnt = ec; e.dir = ed; e.z = ez; e.p = ep; e.rd_chk = rc; e.rd = er; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (tb_cnt !== e.cnt || cnt_down !== e.dir || zero_hit !== e.z ||
                    prd_hit !== e.p || (e.rd_chk && prd_rdata !== e.rd)) begin
                    errors++;
                    $display("FAIL %s: cnt/dir/z/p/rd actual %0d/%0b/%0b/%0b/%0d expected %0d/%0b/%0b/%0b/%0d",
                             e.tag, tb_cnt, cnt_down, zero_hit, prd_hit, prd_rdata,
                             e.cnt, e.dir, e.z, e.p, e.rd);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step("R1", 0, 0, 0, 0, 0, 0, 0, 1, 0);

        // R6 immediate write of period 4
        m_sync = 1; m_imm = 1;
        step("R6", 0, 1, 16'd4, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 16'd4);

        // R2 up count, period 4 -> 5 ticks per cycle; R8 events
        m_mode = 2'b00;
        for (int k = 0; k < 10; k++) begin
            c = 16'(k % 5);
            step("R2", 1, 0, 0, c, 0, c == 0, c == 4, 0, 0);
        end
        step("R2", 1, 0, 0, 0, 0, 1, 0, 0, 0);
        // R7 holds: tick low, then start enable low
        step("R7", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        m_sync = 0;
        step("R7", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        m_sync = 1;
        for (int k = 1; k <= 4; k++)
            step("R7", 1, 0, 0, 16'(k), 0, 0, k == 4, 0, 0);

        // R4 up-down: 0..4..0 in 8 ticks, one peak pulse
        m_mode = 2'b10;
        for (int k = 0; k < 16; k++) begin
            int r;
            r = k % 8;
            c = (r <= 4) ? 16'(r) : 16'(8 - r);
            step("R4", 1, 0, 0, c, (r >= 5) || (r == 0 && k > 0), c == 0, c == 4, 0, 0);
        end

        // R3 down: 0 -> reload 4 -> 3 .. 0
        m_mode = 2'b01;
        for (int k = 0; k < 10; k++) begin
            c = 16'((5 - (k % 5)) % 5);
            step("R3", 1, 0, 0, c, 1, c == 0, c == 4, 0, 0);
        end

        // R5 buffered mode
        m_imm = 0; m_mode = 2'b00;
        step("R5", 0, 1, 16'd2, 0, 1, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 1, 1, 0, 1, 16'd2);
        step("R5", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 2, 0, 0, 1, 0, 0);
        // write lands in the same cycle as the zero transfer
        step("R5", 1, 1, 16'd3, 0, 0, 1, 0, 0, 0);
        step("R5", 1, 0, 0, 1, 0, 0, 0, 1, 16'd3);
        step("R5", 1, 0, 0, 2, 0, 0, 1, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R5", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 2, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 3, 0, 0, 1, 0, 0);

        // R9 stop mode
        step("R9", 1, 0, 0, 0, 0, 1, 0, 0, 0);
        m_mode = 2'b11;
        step("R9", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 1, 0, 0, 0);

        // R9 zero period in up mode
        m_imm = 1;
        step("R9", 0, 1, 16'd0, 0, 0, 0, 0, 0, 0);
        m_mode = 2'b00;
        step("R9", 1, 0, 0, 0, 0, 1, 0, 1, 16'd0);
        step("R9", 1, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 1, 0, 0, 0);

        @(negedge clk);
        tick_en = 0;
        prd_wr = 0;
        repeat (2) @(negedge clk);
        #3;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule